// File: doc/BRIEF.md
# Tamper Monitor Security State Controller

This block keeps the security state of a battery-backed tamper monitor. Two flags, non-valid and violation, encode four states: valid (neither set), non-valid (only non-valid set), failure (only violation set) and non-valid plus failure (both set). Each tamper event line leaves a sticky status bit. An event whose source is enabled also sets the violation flag. While that flag is set the time counter is frozen, so the moment of the violation is kept, and a violation interrupt can be raised.

Software leaves the failure state only through a fixed sequence. First a system reset moves failure to non-valid plus failure, unless the hard lock is set. Then software zeroes the enable register, clears each tamper status bit, clears the violation flag and, as the last step, clears the non-valid flag. Two lock bits can block this sequence. A system reset releases the soft lock. Only a battery-domain reset releases the hard lock.

Software accesses the block through single-cycle register writes. The select value chooses the register: 0 is the status word (write 1 to clear), 1 is the enable register, and 2 is the control register (bit 0 sets the soft lock, bit 1 sets the hard lock, bit 2 is the interrupt enable). The battery-domain reset is `rst_ni`. The system reset is the synchronous pulse `sys_rst_i`.

Top module: `tamper_state_ctrl`

## Requirements
- R1: After a battery-domain reset, status_o holds only the non-valid flag (bit N_SRC+1). Enables, both locks and the interrupt enable are all zero, freeze_o is 0 and viol_irq_o is 0.
- R2: A pulse on evt_i[i] sets status bit i at the next clock edge. If enable bit i is set, the violation flag (bit N_SRC) is also set at that edge.
- R3: An event on a source whose enable bit is clear is recorded in its status bit and does not set the violation flag.
- R4: A write of 1 to status bit N_SRC clears the violation flag only when the non-valid flag is set, all tamper status bits are zero and no event arrives in that cycle. Otherwise the write is ignored, so the flag stays set while any tamper bit is set.
- R5: A write of 1 to tamper status bit i clears it only when enable bit i is zero. An event on line i in the same cycle wins over the clear.
- R6: A write of 1 to status bit N_SRC+1 clears the non-valid flag only if the violation flag was already clear before that write.
- R7: A system reset pulse releases the soft lock and clears the interrupt enable. When the violation flag is set and the hard lock is clear, the pulse also sets the non-valid flag.
- R8: Writes to the enable register (select 1) are ignored while either lock is set.
- R9: Lock bits (status bits N_SRC+2 soft, N_SRC+3 hard) are only set by software writes. A write of 0 leaves them set. The soft lock is released only by R7 or a battery-domain reset. The hard lock is released only by a battery-domain reset.
- R10: freeze_o is high exactly while the violation flag is set. viol_irq_o is high while the violation flag and the interrupt enable (control bit 2) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Battery-domain reset, asynchronous, active low |
| sys_rst_i | input | 1 | System reset pulse, synchronous, active high |
| evt_i | input | N_SRC | Tamper event lines, one per source |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 status, 1 enable, 2 control |
| wr_data_i | input | N_SRC+2 | Write data |
| status_o | output | N_SRC+4 | {hard lock, soft lock, non-valid, violation, tamper bits} |
| freeze_o | output | 1 | Freeze request for the time counter |
| viol_irq_o | output | 1 | Violation interrupt |

## Verification
The bench builds the block with the default N_SRC of 9, so the status word is 13 bits wide. With this width, enabled and disabled sources, and an event colliding with its own clear, can all be exercised in a single recovery walk. The stimulus table runs the full path from non-valid through failure, the system-reset transition, the ordered clears and back to valid. It also probes every refused clear along the way. Directed tests then check lock gating, the difference between the soft and hard lock on a system reset, and the interrupt enable.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_SOFT = 0;
  localparam int unsigned CTRL_HARD = 1;
  localparam int unsigned CTRL_IRQ  = 2;
  localparam int unsigned CTRL_W    = 3;
endpackage

// File: rtl/tsc_event_latch.sv
module tsc_event_latch #(
  parameter int unsigned N_SRC = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] tamper_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    logic hit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  hit_q <= 1'b0;
      else if (evt_i[i])            hit_q <= 1'b1;
      else if (clr_i[i] && !en_i[i]) hit_q <= 1'b0; // source must be disabled first
    end
    assign tamper_o[i] = hit_q;
  end
endmodule

// File: rtl/tsc_cfg_regs.sv
module tsc_cfg_regs
  import tsc_pkg::*;
#(
  parameter int unsigned N_SRC = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_rst_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [N_SRC-1:0] wr_data_i,
  output logic [N_SRC-1:0] en_o,
  output logic             soft_o,
  output logic             hard_o,
  output logic             irq_en_o
);
  logic wr_en_reg, wr_ctrl;
  logic [CTRL_W-1:0] ctrl_d;

  assign wr_en_reg = wr_en_i && (wr_sel_i == SEL_ENABLE);
  assign wr_ctrl   = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign ctrl_d    = wr_data_i[CTRL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= '0;
    else if (wr_en_reg && !soft_o && !hard_o) en_o <= wr_data_i;
  end

  // locks are set-only from software
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        soft_o <= 1'b0;
    else if (sys_rst_i)                 soft_o <= 1'b0;
    else if (wr_ctrl && ctrl_d[CTRL_SOFT]) soft_o <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        hard_o <= 1'b0;
    else if (wr_ctrl && ctrl_d[CTRL_HARD]) hard_o <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_en_o <= 1'b0;
    else if (sys_rst_i) irq_en_o <= 1'b0;
    else if (wr_ctrl)   irq_en_o <= ctrl_d[CTRL_IRQ];
  end
endmodule

// File: rtl/tsc_state_flags.sv
module tsc_state_flags #(
  parameter int unsigned N_SRC = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_rst_i,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] tamper_i,
  input  logic             hard_i,
  input  logic             clr_viol_i,
  input  logic             clr_nv_i,
  output logic             viol_o,
  output logic             nv_o
);
  logic trip, viol_clr_ok;

  assign trip        = |(evt_i & en_i);
  assign viol_clr_ok = clr_viol_i && nv_o && (tamper_i == '0) && (evt_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          viol_o <= 1'b0;
    else if (trip)        viol_o <= 1'b1;
    else if (viol_clr_ok) viol_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             nv_o <= 1'b1;
    else if (sys_rst_i && viol_o && !hard_i) nv_o <= 1'b1;
    else if (clr_nv_i && !viol_o)            nv_o <= 1'b0; // final recovery step
  end
endmodule

// File: rtl/tamper_state_ctrl.sv
module tamper_state_ctrl
  import tsc_pkg::*;
#(
  parameter int unsigned N_SRC = 9,
  localparam int unsigned DW   = N_SRC + 2,
  localparam int unsigned SW   = N_SRC + 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_rst_i,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [SW-1:0]    status_o,
  output logic             freeze_o,
  output logic             viol_irq_o
);
  logic             wr_status;
  logic [N_SRC-1:0] clr_tamper, tamper_q, en_q;
  logic             soft_q, hard_q, irq_en_q, viol_q, nv_q;

  assign wr_status  = wr_en_i && (wr_sel_i == SEL_STATUS);
  assign clr_tamper = wr_status ? wr_data_i[N_SRC-1:0] : '0;

  tsc_event_latch #(.N_SRC(N_SRC)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .en_i     (en_q),
    .clr_i    (clr_tamper),
    .tamper_o (tamper_q)
  );

  tsc_cfg_regs #(.N_SRC(N_SRC)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_rst_i (sys_rst_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i[N_SRC-1:0]),
    .en_o      (en_q),
    .soft_o    (soft_q),
    .hard_o    (hard_q),
    .irq_en_o  (irq_en_q)
  );

  tsc_state_flags #(.N_SRC(N_SRC)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sys_rst_i  (sys_rst_i),
    .evt_i      (evt_i),
    .en_i       (en_q),
    .tamper_i   (tamper_q),
    .hard_i     (hard_q),
    .clr_viol_i (wr_status && wr_data_i[N_SRC]),
    .clr_nv_i   (wr_status && wr_data_i[N_SRC+1]),
    .viol_o     (viol_q),
    .nv_o       (nv_q)
  );

  assign status_o   = {hard_q, soft_q, nv_q, viol_q, tamper_q};
  assign freeze_o   = viol_q;
  assign viol_irq_o = viol_q && irq_en_q;
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int unsigned N_SRC = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sys_rst_i,
  input logic [N_SRC-1:0] evt_i,
  input logic [N_SRC-1:0] en_q,
  input logic             soft_q,
  input logic             hard_q,
  input logic [N_SRC+1:0] flags,
  input logic             freeze_o,
  input logic             viol_irq_o
);
  localparam int unsigned V  = N_SRC;
  localparam int unsigned NV = N_SRC + 1;

  p_trip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(evt_i & en_q) |=> flags[V]);

  p_sticky_viol_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags[V] && (|flags[N_SRC-1:0]) |=> flags[V]);

  p_nv_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flags[NV]) |-> !$past(flags[V]));

  p_sysrst_nv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i && flags[V] && !hard_q |=> flags[NV]);

  p_en_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_q || hard_q) |=> $stable(en_q));

  p_hard_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_q |=> hard_q);

  p_soft_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_q && !sys_rst_i |=> soft_q);

  p_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_irq_o |-> freeze_o);
endmodule

bind tamper_state_ctrl tsc_checker #(.N_SRC(N_SRC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sys_rst_i  (sys_rst_i),
  .evt_i      (evt_i),
  .en_q       (en_q),
  .soft_q     (soft_q),
  .hard_q     (hard_q),
  .flags      (status_o[N_SRC+1:0]),
  .freeze_o   (freeze_o),
  .viol_irq_o (viol_irq_o)
);

// File: tb/tamper_state_ctrl_tb_top.sv
module tamper_state_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 9;
  localparam int DW = N + 2;
  localparam int SW = N + 4;

  typedef struct packed {
    logic          sys;
    logic          we;
    logic [1:0]    sel;
    logic [DW-1:0] data;
    logic [N-1:0]  evt;
    logic [SW-1:0] exp;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 2'd0, 11'h000, 9'h000, 13'h0400, 4'd1},  // R1 idle after reset
    '{1'b0, 1'b1, 2'd0, 11'h400, 9'h000, 13'h0000, 4'd6},  // R6 nv clear, viol clear
    '{1'b0, 1'b0, 2'd0, 11'h000, 9'h001, 13'h0001, 4'd3},  // R3 recorded only
    '{1'b0, 1'b1, 2'd0, 11'h001, 9'h000, 13'h0000, 4'd5},  // R5 clear disabled bit
    '{1'b0, 1'b1, 2'd1, 11'h006, 9'h000, 13'h0000, 4'd8},  // R8 unlocked enable write
    '{1'b0, 1'b0, 2'd0, 11'h000, 9'h008, 13'h0008, 4'd3},  // R3 disabled source
    '{1'b0, 1'b0, 2'd0, 11'h000, 9'h004, 13'h020C, 4'd2},  // R2 enabled source trips
    '{1'b0, 1'b1, 2'd0, 11'h200, 9'h000, 13'h020C, 4'd4},  // R4 refused, nv clear
    '{1'b0, 1'b1, 2'd0, 11'h004, 9'h000, 13'h020C, 4'd5},  // R5 refused, still enabled
    '{1'b1, 1'b0, 2'd0, 11'h000, 9'h000, 13'h060C, 4'd7},  // R7 failure -> nv+failure
    '{1'b0, 1'b1, 2'd0, 11'h200, 9'h000, 13'h060C, 4'd4},  // R4 refused, tamper set
    '{1'b0, 1'b1, 2'd1, 11'h000, 9'h000, 13'h060C, 4'd8},  // R8 zero enables
    '{1'b0, 1'b1, 2'd0, 11'h008, 9'h008, 13'h060C, 4'd5},  // R5 event beats clear
    '{1'b0, 1'b1, 2'd0, 11'h00C, 9'h000, 13'h0600, 4'd5},  // R5 clear tamper bits
    '{1'b0, 1'b1, 2'd0, 11'h600, 9'h000, 13'h0400, 4'd6},  // R6 nv held, R4 viol clears
    '{1'b0, 1'b1, 2'd0, 11'h400, 9'h000, 13'h0000, 4'd6}   // R6 back to valid
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sys_rst_i = 1'b0;
  logic [N-1:0]  evt_i = '0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_sel_i = 2'd0;
  logic [DW-1:0] wr_data_i = '0;
  logic [SW-1:0] status_o;
  logic          freeze_o, viol_irq_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tamper_state_ctrl #(.N_SRC(N)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sys_rst_i  (sys_rst_i),
    .evt_i      (evt_i),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .status_o   (status_o),
    .freeze_o   (freeze_o),
    .viol_irq_o (viol_irq_o)
  );

  task automatic chk(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic sys, input logic we, input logic [1:0] sel,
                      input logic [DW-1:0] data, input logic [N-1:0] evt);
    @(negedge clk_i);
    sys_rst_i = sys; wr_en_i = we; wr_sel_i = sel; wr_data_i = data; evt_i = evt;
    @(negedge clk_i);
    sys_rst_i = 1'b0; wr_en_i = 1'b0; wr_sel_i = 2'd0; wr_data_i = '0; evt_i = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", status_o, 13'h0400);
    chk("R1", {12'h0, freeze_o}, '0);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      step(VECS[k].sys, VECS[k].we, VECS[k].sel, VECS[k].data, VECS[k].evt);
      chk($sformatf("R%0d vec%0d", VECS[k].req, k), status_o, VECS[k].exp);
      chk($sformatf("R10 freeze vec%0d", k), {12'h0, freeze_o}, {12'h0, VECS[k].exp[N]});
    end

    // R9 soft lock set, R8 enable write blocked
    step(1'b0, 1'b1, 2'd2, 11'h001, '0);
    chk("R9", status_o, 13'h0800);
    step(1'b0, 1'b1, 2'd1, 11'h001, '0);
    step(1'b0, 1'b0, 2'd0, 11'h000, 9'h001);
    chk("R8", status_o, 13'h0801);
    step(1'b0, 1'b1, 2'd2, 11'h000, '0);
    chk("R9", status_o, 13'h0801);
    // R7 system reset releases soft lock, no nv without violation
    step(1'b1, 1'b0, 2'd0, 11'h000, '0);
    chk("R7", status_o, 13'h0001);
    step(1'b0, 1'b1, 2'd1, 11'h001, '0);
    step(1'b0, 1'b1, 2'd0, 11'h001, '0);
    chk("R5", status_o, 13'h0001);
    step(1'b0, 1'b0, 2'd0, 11'h000, 9'h001);
    chk("R2", status_o, 13'h0201);
    chk("R10", {12'h0, viol_irq_o}, '0);
    chk("R10", {12'h0, freeze_o}, 13'h1);
    step(1'b0, 1'b1, 2'd2, 11'h006, '0);
    chk("R9", status_o, 13'h1201);
    chk("R10", {12'h0, viol_irq_o}, 13'h1);
    // R7 hard lock blocks nv, interrupt enable cleared
    step(1'b1, 1'b0, 2'd0, 11'h000, '0);
    chk("R7", status_o, 13'h1201);
    chk("R7", {12'h0, viol_irq_o}, '0);
    step(1'b0, 1'b1, 2'd1, 11'h000, '0);
    step(1'b0, 1'b1, 2'd0, 11'h001, '0);
    chk("R8", status_o, 13'h1201);
    // R1 battery-domain reset recovers
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R1", status_o, 13'h0400);
    chk("R1", {12'h0, freeze_o, viol_irq_o}, '0);
    rst_ni = 1'b1;
    step(1'b0, 1'b0, 2'd0, 11'h000, 9'h001);
    chk("R1", status_o, 13'h0401);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule